// File: doc/BRIEF.md
# Address-Region Wait-State Generator

This block lengthens bus accesses on a 20-bit address space. The space is split into eight regions of unequal size. The lowest 64 KB holds four 16 KB regions, numbered 0 to 3. Above that come four regions that each double in size, numbered 4 to 7. Every region owns a 2-bit wait code held in two control registers. When the bus master raises a request with an address, the block decodes the region and selects that region's code. It then holds the ready line low for zero, one or two extra cycles. Under the fourth code it holds ready low for as long as an external active-low wait pin stays low.

The master keeps `req`, `addr` and `we` steady until it sees `ready` high, and drops or renews the request on the following edge. Two address windows are compared against the address as parameters:
- Accesses in the peripheral window are never lengthened.
- A wait-pin code applied inside the internal-ROM window can never end. The block then locks and raises a sticky flag that only reset clears.

The control is one state machine with five named states:
- **IDLE** accepts a request.
  - It finishes the request at once when the access is in the peripheral window or its code is 00.
  - Code 01 or 10 moves it to **COUNT** with the count loaded.
  - Code 11 in the ROM window moves it to **HUNG**.
  - Code 11 anywhere else moves it to **EXT**.
- **COUNT** counts down. When the count is zero it raises ready and returns to IDLE.
- **EXT** waits for the synchronised wait pin to read high, then moves to **RELEASE**.
- **RELEASE** raises ready for one cycle and returns to IDLE.
- **HUNG** has no exit.

Top module: `region_wait_gen`

## Requirements
- R1: The region decode is as follows. 0x00000–0x03FFF is region 0, 0x04000–0x07FFF is region 1, 0x08000–0x0BFFF is region 2 and 0x0C000–0x0FFFF is region 3. 0x10000–0x1FFFF is region 4, 0x20000–0x3FFFF is region 5, 0x40000–0x7FFFF is region 6 and 0x80000–0xFFFFF is region 7.
- R2: With code 00 in the selected region, `ready` is high in the same cycle as the request (zero waits).
- R3: Code 01 gives exactly one wait cycle before `ready`. Code 10 gives exactly two.
- R4: Under code 11 the wait pin passes through two flip-flops. Sampling starts in the first wait cycle, and `ready` rises one cycle after the synchronised pin is seen high. If the pin is already high, the access has 2 waits. If the pin is released k ≥ 1 cycles after the request cycle, the access has k+3 waits.
- R5: The register at 0x0FFC7 holds the codes of regions 0–3, with region i in bits [2i+1:2i]. Its reset value is 0xAA. It reads back on `rdata[7:0]`, and `rdata[15:8]` reads 0.
- R6: The register at 0x0FFC8 holds the codes of regions 4–7 in its low byte, with region 4+i in bits [2i+1:2i].
  - Its reset value is 0xAAAA.
  - Its low byte is write-only and reads as 0.
  - Its upper byte always reads 0xAA, and writes to the upper byte are ignored.
- R7: Accesses in the peripheral window 0x0FE00–0x0FFFF complete with zero waits whatever their code. This includes writes to both control registers.
- R8: Code 11 applied to an access in the ROM window 0x00000–0x07FFF never raises `ready`, whatever the wait pin does. It sets `hang`, which stays high until reset clears it.
- R9: A register write takes effect from the next access.
- R10: `ready` is low whenever no request is pending and the block is idle. After reset `hang` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until `ready` |
| we | input | 1 | Write qualifier for the request |
| addr | input | 20 | Access address |
| wdata | input | 16 | Write data for the control registers |
| wait_n | input | 1 | External active-low wait pin, asynchronous |
| ready | output | 1 | Access completes in this cycle |
| rdata | output | 16 | Control-register read data, decoded from `addr` |
| hang | output | 1 | Sticky lock flag, cleared only by reset |

## Verification
The bench probes both sides of every region boundary with codes that differ across each boundary. A decoder that used uniform region sizes, or slipped by one address bit, would therefore report the neighbour's wait count.

It checks the top of region 3 against the peripheral window, including with code 11 programmed there. A design that let the code override the window would stall register accesses.

It measures the wait-pin latency for a pin released several cycles late. A synchroniser with one flop too few or too many shifts that count by one.

It locks the block in the ROM window with the pin high, then resets it. A flag that cleared itself, or a state machine that escaped on the pin, shows up as a completed access or a low `hang`.

// File: rtl/rwg_pkg.sv
package rwg_pkg;

    localparam int unsigned NUM_REGIONS  = 8;
    localparam int unsigned REGION_IDX_W = $clog2(NUM_REGIONS);
    localparam int unsigned CODE_W       = 2;

    typedef enum logic [CODE_W-1:0] {
        WC_NONE = 2'b00,
        WC_ONE  = 2'b01,
        WC_TWO  = 2'b10,
        WC_EXT  = 2'b11
    } wcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_EXT,
        ST_RELEASE,
        ST_HUNG
    } state_e;

endpackage

// File: rtl/rwg_region_dec.sv
module rwg_region_dec
    import rwg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned SMALL_W = 14
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic [REGION_IDX_W-1:0] region
);
    // Four small regions of 2**SMALL_W bytes, then four doubling regions.
    localparam int unsigned BIG_BASE = SMALL_W + 2;

    logic unused_low;
    assign unused_low = ^addr[SMALL_W-1:0];

    always_comb begin
        region = {1'b0, addr[SMALL_W+1:SMALL_W]};
        // ascending scan: the highest set bit wins
        for (int b = 0; b < 4; b++) begin
            if (addr[BIG_BASE+b]) begin
                region = REGION_IDX_W'(4 + b);
            end
        end
    end

endmodule

// File: rtl/rwg_cfg_regs.sv
module rwg_cfg_regs
    import rwg_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 20,
    parameter int unsigned      DATA_W   = 16,
    parameter logic [ADDR_W-1:0] LO_ADDR = 20'h0FFC7,
    parameter logic [ADDR_W-1:0] HI_ADDR = 20'h0FFC8,
    parameter logic [7:0]       LO_RESET = 8'hAA,
    parameter logic [7:0]       HI_RESET = 8'hAA,
    parameter logic [7:0]       FIXED_HI = 8'hAA
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_stb,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGIONS*CODE_W-1:0]    codes,
    output logic [DATA_W-1:0]                rdata
);
    localparam int unsigned BYTE_W = 8;

    logic [BYTE_W-1:0] low_codes_q;
    logic [BYTE_W-1:0] high_codes_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:BYTE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_codes_q  <= LO_RESET;
            high_codes_q <= HI_RESET;
        end else if (wr_stb) begin
            if (addr == LO_ADDR) low_codes_q  <= wdata[BYTE_W-1:0];
            if (addr == HI_ADDR) high_codes_q <= wdata[BYTE_W-1:0];
        end
    end

    assign codes = {high_codes_q, low_codes_q};

    always_comb begin
        rdata = '0;
        if (addr == LO_ADDR) begin
            rdata[BYTE_W-1:0] = low_codes_q;
        end else if (addr == HI_ADDR) begin
            rdata[2*BYTE_W-1:BYTE_W] = FIXED_HI;
        end
    end

endmodule

// File: rtl/rwg_sync.sv
module rwg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/region_wait_gen.sv
module region_wait_gen
    import rwg_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 20,
    parameter int unsigned       DATA_W      = 16,
    parameter int unsigned       SMALL_W     = 14,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CFG_LO_ADDR = 20'h0FFC7,
    parameter logic [ADDR_W-1:0] CFG_HI_ADDR = 20'h0FFC8,
    parameter logic [ADDR_W-1:0] SFR_LO      = 20'h0FE00,
    parameter logic [ADDR_W-1:0] SFR_HI      = 20'h0FFFF,
    parameter logic [ADDR_W-1:0] ROM_LO      = 20'h00000,
    parameter logic [ADDR_W-1:0] ROM_HI      = 20'h07FFF,
    parameter logic [7:0]        FIXED_HI    = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wait_n,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              hang
);
    localparam int unsigned CNT_W = 2;

    logic [REGION_IDX_W-1:0]          region;
    logic [NUM_REGIONS*CODE_W-1:0]    codes;
    wcode_e                           code;
    logic                             sfr_hit, rom_hit, wait_rel;
    logic                             st_idle, accept, zero_path;
    state_e                           state_q, state_d;
    logic [CNT_W-1:0]                 cnt_q, cnt_d;
    logic                             hang_q;

    rwg_region_dec #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W)) u_dec (
        .addr   (addr),
        .region (region)
    );

    rwg_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LO_ADDR(CFG_LO_ADDR), .HI_ADDR(CFG_HI_ADDR),
        .LO_RESET(8'hAA), .HI_RESET(8'hAA), .FIXED_HI(FIXED_HI)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (accept && we),
        .addr   (addr),
        .wdata  (wdata),
        .codes  (codes),
        .rdata  (rdata)
    );

    rwg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wait_n),
        .q     (wait_rel)
    );

    // window compares written as offset <= span to avoid compares against zero
    assign sfr_hit   = (addr - SFR_LO) <= (SFR_HI - SFR_LO);
    assign rom_hit   = (addr - ROM_LO) <= (ROM_HI - ROM_LO);
    assign code      = wcode_e'(codes[{region, 1'b0} +: CODE_W]);
    assign zero_path = sfr_hit || (code == WC_NONE);
    assign st_idle   = (state_q == ST_IDLE);
    assign accept    = st_idle && req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hang_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hang_q  <= hang_q || (state_d == ST_HUNG);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !zero_path) begin
                    unique case (code)
                        WC_ONE: begin
                            state_d = ST_COUNT;
                            cnt_d   = CNT_W'(0);
                        end
                        WC_TWO: begin
                            state_d = ST_COUNT;
                            cnt_d   = CNT_W'(1);
                        end
                        WC_EXT:  state_d = rom_hit ? ST_HUNG : ST_EXT;
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_COUNT: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_EXT:     if (wait_rel) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            ST_HUNG:    state_d = ST_HUNG;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:    ready = req && zero_path;
            ST_COUNT:   ready = (cnt_q == '0);
            ST_RELEASE: ready = 1'b1;
            default:    ready = 1'b0;
        endcase
        hang = hang_q;
    end

endmodule

// File: rtl/rwg_chk.sv
module rwg_chk #(
    parameter int unsigned       ADDR_W   = 20,
    parameter int unsigned       DATA_W   = 16,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 20'h0FFC8,
    parameter logic [7:0]        FIXED_HI = 8'hAA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              hang,
    input logic              st_idle,
    input logic              sfr_hit,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata
);
    // R8
    hang_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hang |=> hang);

    // R8
    hang_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hang |-> !ready);

    // R7
    sfr_zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && req && sfr_hit) |-> ready);

    // R10
    idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && !req) |-> !ready);

    // R6
    fixed_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == HI_ADDR) |-> (rdata[15:8] == FIXED_HI));

endmodule

bind region_wait_gen rwg_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_ADDR(CFG_HI_ADDR), .FIXED_HI(FIXED_HI)
) u_rwg_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .ready   (ready),
    .hang    (hang),
    .st_idle (st_idle),
    .sfr_hit (sfr_hit),
    .addr    (addr),
    .rdata   (rdata)
);

// File: tb/tb_region_wait_gen.sv
module tb_region_wait_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        wait_n = 1'b1;
    logic        ready;
    logic [15:0] rdata;
    logic        hang;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    int wcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    region_wait_gen dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .wait_n(wait_n), .ready(ready), .rdata(rdata), .hang(hang)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: counts wait cycles per access and compares with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst_n) begin
                wcnt = 0;
            end else if (req) begin
                if (ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "unexpected completion", wcnt, -1);
                    end else begin
                        int e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(wcnt == e, t, wcnt, e);
                    end
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // driver: called at a falling edge, returns at a falling edge with req low
    task automatic access(input logic [19:0] a, input bit w, input logic [15:0] d,
                          input int exp, input string tag);
        int guard = 0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req = 1'b1; we = w; addr = a; wdata = d;
        #3;
        while (!ready && guard < 60) begin
            @(negedge clk);
            #3;
            guard++;
        end
        if (guard >= 60) check(1'b0, {tag, " timeout"}, guard, exp);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic read_chk(input logic [19:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        #3;
        check(rdata == exp, tag, rdata, exp);
        @(negedge clk);
    endtask

    task automatic do_reset();
        req = 1'b0; we = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // reset state
        #3;
        check(ready == 1'b0, "R10 idle ready", ready, 0);
        check(hang == 1'b0, "R10 hang after reset", hang, 0);
        @(negedge clk);
        read_chk(20'h0FFC7, 16'h00AA, "R5 reset value");
        read_chk(20'h0FFC8, 16'hAA00, "R6 reset readback");
        // reset codes are 10 everywhere: two waits
        access(20'h00000, 1'b0, '0, 2, "R3 reset code region0");
        access(20'h80000, 1'b0, '0, 2, "R6 reset code region7");

        // program codes: r0=00 r1=01 r2=10 r3=01 ; r4=00 r5=01 r6=10 r7=00
        access(20'h0FFC7, 1'b1, 16'h0064, 0, "R7 write low register");
        access(20'h0FFC8, 1'b1, 16'h5524, 0, "R7 write high register");
        read_chk(20'h0FFC7, 16'h0064, "R5 readback");
        read_chk(20'h0FFC8, 16'hAA00, "R6 upper byte write ignored");

        // region boundaries (R1), next access uses new codes (R9)
        access(20'h00000, 1'b0, '0, 0, "R9 R2 region0 low");
        access(20'h03FFF, 1'b0, '0, 0, "R1 R2 region0 high");
        access(20'h04000, 1'b0, '0, 1, "R1 R3 region1 low");
        access(20'h07FFF, 1'b0, '0, 1, "R1 region1 high");
        access(20'h08000, 1'b0, '0, 2, "R1 R3 region2 low");
        access(20'h0BFFF, 1'b0, '0, 2, "R1 region2 high");
        access(20'h0C000, 1'b0, '0, 1, "R1 region3 low");
        access(20'h0FDFF, 1'b0, '0, 1, "R1 region3 below window");
        access(20'h0FFFF, 1'b0, '0, 0, "R7 peripheral window top");
        access(20'h10000, 1'b0, '0, 0, "R1 region4 low");
        access(20'h1FFFF, 1'b0, '0, 0, "R1 region4 high");
        access(20'h20000, 1'b0, '0, 1, "R1 region5 low");
        access(20'h3FFFF, 1'b0, '0, 1, "R1 region5 high");
        access(20'h40000, 1'b0, '0, 2, "R1 region6 low");
        access(20'h7FFFF, 1'b0, '0, 2, "R1 region6 high");
        access(20'h80000, 1'b0, '0, 0, "R1 region7 low");
        access(20'hFFFFF, 1'b0, '0, 0, "R1 region7 high");

        // code 11 in region3 must not stretch the peripheral window
        access(20'h0FFC7, 1'b1, 16'h00E4, 0, "R7 write low register again");
        access(20'h0FE00, 1'b0, '0, 0, "R7 window bottom code11");

        // wait pin: region7 code 11
        access(20'h0FFC8, 1'b1, 16'h00E4, 0, "R7 write high register again");
        access(20'h80000, 1'b0, '0, 2, "R4 pin already high");
        wait_n = 1'b0;
        repeat (4) @(negedge clk);
        fork
            access(20'hC0000, 1'b0, '0, 7, "R4 pin released after 4");
            begin
                repeat (4) @(negedge clk);
                wait_n = 1'b1;
            end
        join
        wait_n = 1'b0;
        repeat (4) @(negedge clk);
        fork
            access(20'hFFFFF, 1'b0, '0, 4, "R4 pin released after 1");
            begin
                repeat (1) @(negedge clk);
                wait_n = 1'b1;
            end
        join

        // deadlock: region0 (ROM) code 11
        access(20'h0FFC7, 1'b1, 16'h0067, 0, "R7 write region0 code11");
        req = 1'b1; we = 1'b0; addr = 20'h00100; wait_n = 1'b1;
        repeat (20) @(negedge clk);
        #3;
        check(ready == 1'b0, "R8 no completion", ready, 0);
        check(hang == 1'b1, "R8 hang flag set", hang, 1);
        @(negedge clk);
        req = 1'b0;
        repeat (5) @(negedge clk);
        #3;
        check(hang == 1'b1, "R8 hang sticky", hang, 1);
        @(negedge clk);
        do_reset();
        #3;
        check(hang == 1'b0, "R8 hang cleared by reset", hang, 0);
        @(negedge clk);
        read_chk(20'h0FFC7, 16'h00AA, "R5 reset after lock");
        access(20'h00100, 1'b0, '0, 2, "R8 access after reset");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule